// File: doc/BRIEF.md
# Memory Device Power State Controller

This block keeps track of the power mode of a single memory device that sits on a packet-based channel. Decoded command strobes come in from the row and column packet decoders, and the block turns them into one of six power states: deep sleep (powerdown), light sleep (nap), idle (standby), attention, attention with read data pending, and attention with write data pending. From the current state it works out which receive paths must stay powered. A wake-up from either sleep state follows a two-phase timed sequence. The length of the first phase is set by a programmable multiplier field, one field for each sleep depth. The second phase is 23 or 8 core cycles, depending on the self-refresh select bit.

Wake-up needs a request addressed to this device with the correct command code. The level of the serial line at that moment selects whether the device wakes into attention or into standby. Once a wake-up completes, a programmable hold-off window stops the device from going straight back to sleep. A command that is not allowed in the current state leaves the state unchanged and sets a sticky error flag.

Top module: `dram_pwr_state_ctl`

## Requirements
- R1: Synchronous reset puts the device in powerdown when `init_pdn` is 1 and in standby when it is 0, and clears `err`. The state codes are 0 powerdown, 1 nap, 2 standby, 3 attention, 4 attention-read, 5 attention-write.
- R2: From standby or any attention state, a non-broadcast attention strobe moves the device to attention on the next edge. When `row_bcast` is 1 the strobe is ignored: the state does not change and no error is raised.
- R3: A relax strobe moves an awake device to standby on the next edge.
- R4: From an attention state, `rd_stb` moves the device to attention-read and `wr_stb` moves it to attention-write.
- R5: A nap strobe puts an awake device into nap on the next edge. A powerdown strobe takes effect one cycle later, so the device is in powerdown after the second edge. Any command that arrives in that intermediate cycle is illegal.
- R6: An exit strobe is acted on only when `exit_dev_match` is 1 and `exit_cmd` equals 2'b01. In every other case it is ignored without an error.
- R7: An accepted exit raises `exit_busy` at once, and the device stays in its sleep state for A+B cycles. A is 5 + (2 + M·X)·4 cycles. For powerdown, X is `pdnx` and M is 256. For nap, X is `napx` and M is 1.
- R8: B is 23 cycles when `nsr` is 1 and 8 cycles when `nsr` is 0.
- R9: When the exit finishes, the device goes to attention if `sio0` was 1 at the accepted exit, and to standby otherwise.
- R10: For `hold_cyc` cycles after an exit finishes, `hold_win` is 1 and nap and powerdown strobes are illegal. On the cycle after the window ends they are accepted.
- R11: A command that is illegal in the current state leaves the state unchanged and sets `err`. Only reset clears `err`.
- R12: `row_rdy` is 1 in standby and in the attention states. `col_rdy` is 1 in the attention states. `rdata_rdy` is 1 only in attention-read and `wdata_rdy` only in attention-write.
- R13: When several strobes arrive in one cycle, only the highest one is evaluated. The order from highest to lowest is exit, powerdown, nap, relax, attention, write, read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| init_pdn | input | 1 | Power-up init bit: start in powerdown |
| row_attn_stb | input | 1 | Row packet attention command strobe |
| row_bcast | input | 1 | Row packet is broadcast |
| rlx_stb | input | 1 | Relax command strobe (row or column packet) |
| nap_stb | input | 1 | Nap entry command strobe |
| pdn_stb | input | 1 | Powerdown entry command strobe |
| rd_stb | input | 1 | Read column command strobe |
| wr_stb | input | 1 | Write column command strobe |
| exit_stb | input | 1 | Sleep exit request strobe |
| exit_dev_match | input | 1 | Exit request addresses this device |
| exit_cmd | input | 2 | Exit request command code |
| sio0 | input | 1 | Serial line level, picks the wake target |
| nsr | input | 1 | Self-refresh select: long second phase |
| napx | input | NAPX_W | Nap exit multiplier field |
| pdnx | input | PDNX_W | Powerdown exit multiplier field |
| hold_cyc | input | HOLD_W | Sleep hold-off length after exit |
| state | output | 3 | Current power state code |
| row_rdy | output | 1 | Row receiver must be on |
| col_rdy | output | 1 | Column receiver must be on |
| rdata_rdy | output | 1 | Read data path must be on |
| wdata_rdy | output | 1 | Write data receiver must be on |
| exit_busy | output | 1 | Exit sequence in progress |
| hold_win | output | 1 | Post-exit hold-off window active |
| err | output | 1 | Sticky illegal-command flag |

## Verification
The case of interest is a sleep request that arrives on the last cycle of the post-exit hold-off window, where the window counter is expiring and a new command is being evaluated on the same edge. The bench completes a nap exit with a three-cycle window and issues a nap strobe on the third cycle after completion. That strobe must be rejected with `err` set and the state left in standby. It then repeats the same sequence from reset, issues the strobe one cycle later, and expects nap to be entered with no error. A second coincidence is the powerdown hand-over cycle. An attention strobe issued there must raise `err`, and the device must still end up in powerdown.

// File: rtl/psc_pkg.sv
package psc_pkg;

    typedef enum logic [2:0] {
        PS_PDN   = 3'd0,
        PS_NAP   = 3'd1,
        PS_STBY  = 3'd2,
        PS_ATTN  = 3'd3,
        PS_ATTNR = 3'd4,
        PS_ATTNW = 3'd5
    } pstate_e;

    typedef enum logic [2:0] {
        PC_NONE = 3'd0,
        PC_EXIT = 3'd1,
        PC_PDN  = 3'd2,
        PC_NAP  = 3'd3,
        PC_RLX  = 3'd4,
        PC_ATTN = 3'd5,
        PC_WR   = 3'd6,
        PC_RD   = 3'd7
    } pcmd_e;

    typedef enum logic [1:0] {
        XP_IDLE = 2'd0,
        XP_A    = 2'd1,
        XP_B    = 2'd2
    } xphase_e;

    typedef struct packed {
        logic    legal;
        logic    illegal;
        pstate_e nxt;
    } verdict_t;

    localparam logic [1:0] EXIT_CODE = 2'b01;

    function automatic logic in_sleep(pstate_e s);
        return (s == PS_PDN) || (s == PS_NAP);
    endfunction

    function automatic logic in_attn(pstate_e s);
        return (s == PS_ATTN) || (s == PS_ATTNR) || (s == PS_ATTNW);
    endfunction

    function automatic logic in_awake(pstate_e s);
        return (s == PS_STBY) || in_attn(s);
    endfunction

endpackage

// File: rtl/psc_cmd_sel.sv
module psc_cmd_sel
    import psc_pkg::*;
(
    input  logic       row_attn_stb,
    input  logic       row_bcast,
    input  logic       rlx_stb,
    input  logic       nap_stb,
    input  logic       pdn_stb,
    input  logic       rd_stb,
    input  logic       wr_stb,
    input  logic       exit_stb,
    input  logic       exit_dev_match,
    input  logic [1:0] exit_cmd,
    output pcmd_e      cmd
);
    logic exit_q;
    logic attn_q;

    assign exit_q = exit_stb && exit_dev_match && (exit_cmd == EXIT_CODE);
    assign attn_q = row_attn_stb && !row_bcast;

    // Fixed priority: exit, powerdown, nap, relax, attention, write, read
    always_comb begin
        if (exit_q)       cmd = PC_EXIT;
        else if (pdn_stb) cmd = PC_PDN;
        else if (nap_stb) cmd = PC_NAP;
        else if (rlx_stb) cmd = PC_RLX;
        else if (attn_q)  cmd = PC_ATTN;
        else if (wr_stb)  cmd = PC_WR;
        else if (rd_stb)  cmd = PC_RD;
        else              cmd = PC_NONE;
    end

endmodule

// File: rtl/psc_legal_chk.sv
module psc_legal_chk
    import psc_pkg::*;
(
    input  pcmd_e    cmd,
    input  pstate_e  cur,
    input  logic     busy,
    input  logic     pend,
    input  logic     hold,
    output verdict_t v
);
    logic blocked;
    assign blocked = busy || pend;

    always_comb begin
        v.legal = 1'b0;
        v.nxt   = cur;
        case (cmd)
            PC_EXIT: v.legal = in_sleep(cur) && !blocked;
            PC_PDN: v.legal = in_awake(cur) && !blocked && !hold;
            PC_NAP: begin
                v.legal = in_awake(cur) && !blocked && !hold;
                v.nxt   = PS_NAP;
            end
            PC_RLX: begin
                v.legal = in_awake(cur) && !blocked;
                v.nxt   = PS_STBY;
            end
            PC_ATTN: begin
                v.legal = in_awake(cur) && !blocked;
                v.nxt   = PS_ATTN;
            end
            PC_WR: begin
                v.legal = in_attn(cur) && !blocked;
                v.nxt   = PS_ATTNW;
            end
            PC_RD: begin
                v.legal = in_attn(cur) && !blocked;
                v.nxt   = PS_ATTNR;
            end
            default: v.legal = 1'b0;
        endcase
        v.illegal = (cmd != PC_NONE) && !v.legal;
        if (!v.legal) v.nxt = cur;
    end

endmodule

// File: rtl/psc_exit_timer.sv
module psc_exit_timer
    import psc_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int PDNX_W    = 4,
    parameter int NAPX_W    = 5,
    parameter int HOLD_W    = 6,
    parameter int SCK_RATIO = 4,
    parameter int FIX_A     = 5,
    parameter int PDN_MULT  = 256,
    parameter int NAP_MULT  = 1,
    parameter int PHB_SR    = 23,
    parameter int PHB_NSR   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              from_pdn,
    input  logic [PDNX_W-1:0] pdnx,
    input  logic [NAPX_W-1:0] napx,
    input  logic              nsr,
    input  logic [HOLD_W-1:0] hold_cyc,
    output logic              busy,
    output logic              done,
    output logic              hold_win
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    xphase_e           phase;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  len_a;
    logic [CNT_W-1:0]  len_b;
    logic [HOLD_W-1:0] hold_cnt;
    logic [CNT_W-1:0]  mult_term;

    always_comb begin
        if (from_pdn) mult_term = CNT_W'(PDN_MULT) * CNT_W'(pdnx);
        else          mult_term = CNT_W'(NAP_MULT) * CNT_W'(napx);
        len_a = CNT_W'(FIX_A) + (CNT_W'(2) + mult_term) * CNT_W'(SCK_RATIO);
        len_b = nsr ? CNT_W'(PHB_SR) : CNT_W'(PHB_NSR);
    end

    assign busy     = (phase != XP_IDLE);
    assign done     = (phase == XP_B) && (cnt == ONE);
    assign hold_win = (hold_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= XP_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                XP_IDLE: if (start) begin
                    phase <= XP_A;
                    cnt   <= len_a;
                end
                XP_A: if (cnt == ONE) begin
                    phase <= XP_B;
                    cnt   <= len_b;
                end else begin
                    cnt <= cnt - ONE;
                end
                XP_B: if (cnt == ONE) begin
                    phase <= XP_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt - ONE;
                end
                default: phase <= XP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)              hold_cnt <= '0;
        else if (done)        hold_cnt <= hold_cyc;
        else if (hold_win)    hold_cnt <= hold_cnt - 1'b1;
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        start |=> busy); // R7
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R7
    AST_HOLD_OPENS: assert property (@(posedge clk) disable iff (rst)
        (done && hold_cyc != '0) |=> hold_win); // R10

endmodule

// File: rtl/dram_pwr_state_ctl.sv
module dram_pwr_state_ctl
    import psc_pkg::*;
#(
    parameter int PDNX_W    = 4,
    parameter int NAPX_W    = 5,
    parameter int HOLD_W    = 6,
    parameter int SCK_RATIO = 4,
    parameter int CNT_W     = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_pdn,
    input  logic              row_attn_stb,
    input  logic              row_bcast,
    input  logic              rlx_stb,
    input  logic              nap_stb,
    input  logic              pdn_stb,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic              exit_stb,
    input  logic              exit_dev_match,
    input  logic [1:0]        exit_cmd,
    input  logic              sio0,
    input  logic              nsr,
    input  logic [NAPX_W-1:0] napx,
    input  logic [PDNX_W-1:0] pdnx,
    input  logic [HOLD_W-1:0] hold_cyc,
    output logic [2:0]        state,
    output logic              row_rdy,
    output logic              col_rdy,
    output logic              rdata_rdy,
    output logic              wdata_rdy,
    output logic              exit_busy,
    output logic              hold_win,
    output logic              err
);
    pstate_e  st;
    logic     pend;
    logic     to_attn;
    pcmd_e    cmd;
    verdict_t v;
    logic     x_start;
    logic     x_done;

    psc_cmd_sel u_sel (
        .row_attn_stb   (row_attn_stb),
        .row_bcast      (row_bcast),
        .rlx_stb        (rlx_stb),
        .nap_stb        (nap_stb),
        .pdn_stb        (pdn_stb),
        .rd_stb         (rd_stb),
        .wr_stb         (wr_stb),
        .exit_stb       (exit_stb),
        .exit_dev_match (exit_dev_match),
        .exit_cmd       (exit_cmd),
        .cmd            (cmd)
    );

    psc_legal_chk u_chk (
        .cmd  (cmd),
        .cur  (st),
        .busy (exit_busy),
        .pend (pend),
        .hold (hold_win),
        .v    (v)
    );

    assign x_start = v.legal && (cmd == PC_EXIT);

    psc_exit_timer #(
        .CNT_W     (CNT_W),
        .PDNX_W    (PDNX_W),
        .NAPX_W    (NAPX_W),
        .HOLD_W    (HOLD_W),
        .SCK_RATIO (SCK_RATIO)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .start    (x_start),
        .from_pdn (st == PS_PDN),
        .pdnx     (pdnx),
        .napx     (napx),
        .nsr      (nsr),
        .hold_cyc (hold_cyc),
        .busy     (exit_busy),
        .done     (x_done),
        .hold_win (hold_win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= init_pdn ? PS_PDN : PS_STBY;
            pend    <= 1'b0;
            to_attn <= 1'b0;
            err     <= 1'b0;
        end else begin
            if (v.illegal) err <= 1'b1;
            if (x_done) begin
                st <= to_attn ? PS_ATTN : PS_STBY;
            end else if (pend) begin
                st   <= PS_PDN;
                pend <= 1'b0;
            end else if (v.legal) begin
                st <= v.nxt;
                if (cmd == PC_PDN)  pend    <= 1'b1;
                if (cmd == PC_EXIT) to_attn <= sio0;
            end
        end
    end

    assign state     = st;
    assign row_rdy   = in_awake(st);
    assign col_rdy   = in_attn(st);
    assign rdata_rdy = (st == PS_ATTNR);
    assign wdata_rdy = (st == PS_ATTNW);

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R11
    AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (v.illegal && !pend && !x_done) |=> $stable(st)); // R11
    AST_PEND_ENTERS_PDN: assert property (@(posedge clk) disable iff (rst)
        pend |=> (st == PS_PDN)); // R5
    AST_BUSY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        exit_busy |-> in_sleep(st)); // R7
    AST_BCAST_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (row_attn_stb && row_bcast && !rlx_stb && !nap_stb && !pdn_stb &&
         !rd_stb && !wr_stb && !exit_stb && st == PS_STBY && !pend)
        |=> (st == PS_STBY)); // R2
    AST_HOLD_NO_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (hold_win && (nap_stb || pdn_stb)) |=> (!in_sleep(st) && !pend)); // R10

endmodule

// File: tb/dram_pwr_state_ctl_tb.sv
`timescale 1ns/1ps
module dram_pwr_state_ctl_tb;

    localparam int S_PDN = 0, S_NAP = 1, S_STBY = 2, S_ATTN = 3, S_ATTNR = 4, S_ATTNW = 5;
    localparam logic [6:0] M_ATTN = 7'h01, M_RLX = 7'h02, M_NAP = 7'h04, M_PDN = 7'h08,
                           M_RD = 7'h10, M_WR = 7'h20, M_EXIT = 7'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_pdn = 1'b0;
    logic row_attn_stb = 1'b0, row_bcast = 1'b0, rlx_stb = 1'b0, nap_stb = 1'b0;
    logic pdn_stb = 1'b0, rd_stb = 1'b0, wr_stb = 1'b0, exit_stb = 1'b0;
    logic exit_dev_match = 1'b1;
    logic [1:0] exit_cmd = 2'b01;
    logic sio0 = 1'b0, nsr = 1'b0;
    logic [4:0] napx = '0;
    logic [3:0] pdnx = '0;
    logic [5:0] hold_cyc = '0;
    logic [2:0] state;
    logic row_rdy, col_rdy, rdata_rdy, wdata_rdy, exit_busy, hold_win, err;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dram_pwr_state_ctl u_dut (
        .clk(clk), .rst(rst), .init_pdn(init_pdn),
        .row_attn_stb(row_attn_stb), .row_bcast(row_bcast), .rlx_stb(rlx_stb),
        .nap_stb(nap_stb), .pdn_stb(pdn_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .exit_stb(exit_stb), .exit_dev_match(exit_dev_match), .exit_cmd(exit_cmd),
        .sio0(sio0), .nsr(nsr), .napx(napx), .pdnx(pdnx), .hold_cyc(hold_cyc),
        .state(state), .row_rdy(row_rdy), .col_rdy(col_rdy), .rdata_rdy(rdata_rdy),
        .wdata_rdy(wdata_rdy), .exit_busy(exit_busy), .hold_win(hold_win), .err(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [6:0] m);
        {exit_stb, wr_stb, rd_stb, pdn_stb, nap_stb, rlx_stb, row_attn_stb} = m;
        step();
        {exit_stb, wr_stb, rd_stb, pdn_stb, nap_stb, rlx_stb, row_attn_stb} = '0;
    endtask

    task automatic do_reset(input logic init);
        rst = 1'b1;
        init_pdn = init;
        row_bcast = 1'b0;
        exit_dev_match = 1'b1;
        exit_cmd = 2'b01;
        step();
        step();
        rst = 1'b0;
    endtask

    function automatic int len_a(input int mult, input int x);
        return 5 + (2 + mult * x) * 4;
    endfunction

    // exit already accepted; wait out the full sequence and check the landing
    task automatic run_exit(input string tag, input int total, input int sleep_st, input int tgt);
        chk({tag, " busy at start"}, exit_busy, 1);
        repeat (total - 1) step();
        chk({tag, " still asleep"}, state, sleep_st);
        chk({tag, " busy last cycle"}, exit_busy, 1);
        step();
        chk({tag, " target"}, state, tgt);
        chk({tag, " busy cleared"}, exit_busy, 0);
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 stby after reset", state, S_STBY);
        chk("R1 err clear", err, 0);
        chk("R12 row_rdy stby", row_rdy, 1);
        chk("R12 col_rdy stby", col_rdy, 0);
        do_reset(1'b1);
        chk("R1 pdn after reset", state, S_PDN);
        chk("R12 row_rdy pdn", row_rdy, 0);
    endtask

    task automatic t_attention();
        do_reset(1'b0);
        row_bcast = 1'b1;
        pulse(M_ATTN);
        row_bcast = 1'b0;
        chk("R2 bcast ignored", state, S_STBY);
        chk("R2 bcast no err", err, 0);
        pulse(M_ATTN);
        chk("R2 attn", state, S_ATTN);
        chk("R12 col_rdy attn", col_rdy, 1);
        pulse(M_WR);
        chk("R4 write", state, S_ATTNW);
        chk("R12 wdata_rdy", wdata_rdy, 1);
        chk("R12 rdata_rdy off", rdata_rdy, 0);
        pulse(M_RD);
        chk("R4 read", state, S_ATTNR);
        chk("R12 rdata_rdy", rdata_rdy, 1);
        pulse(M_RLX);
        chk("R3 relax", state, S_STBY);
        chk("R11 no err legal seq", err, 0);
    endtask

    task automatic t_illegal();
        do_reset(1'b0);
        pulse(M_RD);
        chk("R11 rd in stby state kept", state, S_STBY);
        chk("R11 err set", err, 1);
        step();
        step();
        chk("R11 err sticky", err, 1);
    endtask

    task automatic t_priority();
        do_reset(1'b0);
        pulse(M_NAP | M_RLX | M_ATTN);
        chk("R13 nap beats relax/attn", state, S_NAP);
        do_reset(1'b0);
        pulse(M_ATTN | M_WR);
        chk("R13 attn beats write", state, S_ATTN);
        chk("R13 no err", err, 0);
    endtask

    task automatic t_pdn_entry();
        do_reset(1'b0);
        pulse(M_PDN);
        chk("R5 pdn not yet", state, S_STBY);
        step();
        chk("R5 pdn entered", state, S_PDN);
        do_reset(1'b0);
        pulse(M_PDN);
        pulse(M_ATTN);
        chk("R5 cmd in pend illegal", err, 1);
        chk("R5 pdn still entered", state, S_PDN);
    endtask

    task automatic t_nap_exit_hold(input int gap);
        do_reset(1'b0);
        nsr = 1'b0; napx = 5'd0; sio0 = 1'b0; hold_cyc = 6'd3;
        pulse(M_NAP);
        chk("R5 nap entered", state, S_NAP);
        exit_dev_match = 1'b0;
        pulse(M_EXIT);
        chk("R6 no match ignored", exit_busy, 0);
        exit_dev_match = 1'b1; exit_cmd = 2'b10;
        pulse(M_EXIT);
        chk("R6 bad code ignored", exit_busy, 0);
        chk("R6 no err", err, 0);
        exit_cmd = 2'b01;
        pulse(M_EXIT);
        run_exit("R7 R8 R9 nap exit", len_a(1, 0) + 8, S_NAP, S_STBY);
        chk("R10 window open", hold_win, 1);
        repeat (gap - 1) step();
        pulse(M_NAP);
        if (gap <= 3) begin
            chk("R10 nap in window rejected", state, S_STBY);
            chk("R10 err in window", err, 1);
        end else begin
            chk("R10 nap after window", state, S_NAP);
            chk("R10 no err after window", err, 0);
        end
    endtask

    task automatic t_pdn_exit();
        do_reset(1'b1);
        nsr = 1'b1; pdnx = 4'd1; sio0 = 1'b1; hold_cyc = 6'd0;
        pulse(M_EXIT);
        sio0 = 1'b0;
        run_exit("R7 R8 R9 pdn exit", len_a(256, 1) + 23, S_PDN, S_ATTN);
        chk("R10 no window", hold_win, 0);
    endtask

    task automatic t_napx_exit();
        do_reset(1'b0);
        nsr = 1'b1; napx = 5'd3; sio0 = 1'b1; hold_cyc = 6'd0;
        pulse(M_NAP);
        pulse(M_EXIT);
        run_exit("R7 napx exit", len_a(1, 3) + 23, S_NAP, S_ATTN);
    endtask

    bit finished = 1'b0;

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_attention();
        t_illegal();
        t_priority();
        t_pdn_entry();
        t_nap_exit_hold(3);
        t_nap_exit_hold(4);
        t_pdn_exit();
        t_napx_exit();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule